// File: doc/BRIEF.md
# Peripheral Module Power-State Controller

This block holds a power state for each of up to 64 peripheral modules. It turns that state into a clock enable and a local reset for each module. Software reaches it through a simple word-addressed register port. For every module it stages a requested state code and a local-reset level in that module's control register. It then writes a single commit command, and the command moves every module to its staged state together.

A commit runs for a fixed number of cycles. During that window a global busy flag stays set and the reported states do not move. At the end of the window every module's status register reports the state that was staged when the command was accepted. The local-reset level is not part of the commit and reaches its output one edge after the control write. Software waits on the busy flag and then reads the per-module status words to confirm that the change has landed.

Top module: `psc_ctrl`

## Requirements
- R1: After reset, every control register and status register reads 0, the busy flag is 0, every `mod_clk_en` bit is 0 and every `mod_rst_n` bit is 0.
- R2: The control register of module n sits at byte address 0xA00 + 4n and reads back all 32 bits exactly as written. Read data appears on `reg_rdata` one clock edge after `reg_rd` is sampled.
- R3: Writing a control register by itself does not change any status register or any `mod_clk_en` bit.
- R4: A write to address 0x120 with data bit 0 set, made while idle, sets `xfer_busy` and bit 0 of the word at 0x128 on the next edge. The flag then stays set for exactly XFER_CYCLES cycles. The same write with data bit 0 clear does nothing.
- R5: The status register of module n sits at 0x800 + 4n. Its bits 4:0 report the current state and its upper bits read 0. It holds its value throughout a busy window and changes only on the edge that clears busy.
- R6: When a window ends, the status of each module equals bits 4:0 of its control register as they were on the edge that accepted the command. Control writes made later take effect only at the next command.
- R7: State codes are 0 (off, held in reset), 1 (synchronous reset), 2 (clock gated) and 3 (running). `mod_clk_en[n]` is 1 exactly when module n's current state is 3.
- R8: `mod_rst_n[n]` equals bit 8 of module n's control register from the edge after the write onward. It needs no command.
- R9: A commit command issued while busy is ignored. It neither lengthens the running window nor starts a second one.
- R10: Reads of 0x120 and of unmapped or unaligned addresses return 0. Writes to unmapped addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| xfer_busy | output | 1 | Commit window in progress |
| mod_clk_en | output | NUM_MOD | Per-module clock enable |
| mod_rst_n | output | NUM_MOD | Per-module active-low local reset |

## Verification
Each result has a fixed due cycle:
- `xfer_busy` rises on the edge that samples the command.
- It stays high for XFER_CYCLES sampled cycles and falls on the following edge, which is also the edge that updates status and the clock enables.
- `mod_rst_n` changes on the edge that samples the control write.
- Read data is due one edge after the read strobe.

The bench drives on falling edges and samples on the falling edge that follows each due edge. It counts every sample of `xfer_busy` through the window, so a window that is one cycle short or long is caught. It also checks the clock enables on every sample of the window, so they are confirmed to hold still until the final edge.

// File: rtl/psc_pkg.sv
package psc_pkg;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 12;
  localparam int STATE_W = 5;
  localparam int LRST_BIT = 8;

  typedef enum logic [STATE_W-1:0] {
    MS_OFF_RESET  = 5'd0,
    MS_SYNC_RESET = 5'd1,
    MS_GATED      = 5'd2,
    MS_RUN        = 5'd3
  } mod_state_e;

  localparam logic [ADDR_W-1:0] ADDR_GO   = 12'h120;
  localparam logic [ADDR_W-1:0] ADDR_BUSY = 12'h128;
  localparam logic [3:0]        PAGE_STAT = 4'h8;
  localparam logic [3:0]        PAGE_CTRL = 4'hA;
endpackage

// File: rtl/psc_addr_dec.sv
module psc_addr_dec
  import psc_pkg::*;
#(
  parameter int NUM_MOD = 64
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_go,
  output logic              hit_busy,
  output logic              hit_ctrl,
  output logic              hit_stat,
  output logic [5:0]        idx
);
  logic aligned;
  logic in_range;

  always_comb begin
    aligned  = (addr[1:0] == 2'b00);
    idx      = addr[7:2];
    in_range = ({1'b0, addr[7:2]} < 7'(NUM_MOD));
    hit_go   = (addr == ADDR_GO);
    hit_busy = (addr == ADDR_BUSY);
    hit_ctrl = aligned && in_range && (addr[11:8] == PAGE_CTRL);
    hit_stat = aligned && in_range && (addr[11:8] == PAGE_STAT);
  end
endmodule

// File: rtl/psc_ctrl_bank.sv
module psc_ctrl_bank
  import psc_pkg::*;
#(
  parameter int NUM_MOD = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_MOD-1:0] wr_sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl_q [NUM_MOD]
);
  genvar i;
  generate
    for (i = 0; i < NUM_MOD; i++) begin : g_reg
      logic [DATA_W-1:0] ctrl_d;
      logic              ctrl_en;

      always_comb begin
        ctrl_en = wr_sel[i];
        ctrl_d  = wdata;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ctrl_q[i] <= '0;
        else if (ctrl_en) ctrl_q[i] <= ctrl_d;
      end
    end
  endgenerate
endmodule

// File: rtl/psc_xfer_seq.sv
module psc_xfer_seq #(
  parameter int XFER_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go_req,
  output logic busy_q,
  output logic accept,
  output logic commit
);
  localparam int CNT_W = (XFER_CYCLES < 2) ? 1 : $clog2(XFER_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(XFER_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_d;

  always_comb begin
    accept = go_req && !busy_q;
    commit = busy_q && (cnt_q == '0);
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (accept) begin
      busy_d = 1'b1;
      cnt_d  = CNT_LOAD;
    end else if (commit) begin
      busy_d = 1'b0;
    end else if (busy_q) begin
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  AST_GO_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    go_req && !busy_q |=> busy_q); // R4
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && (cnt_q != '0) |=> busy_q); // R4
  AST_NO_EXTEND: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !busy_q); // R9
endmodule

// File: rtl/psc_state_bank.sv
module psc_state_bank
  import psc_pkg::*;
#(
  parameter int NUM_MOD = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               snap,
  input  logic               commit,
  input  logic [STATE_W-1:0] req_state [NUM_MOD],
  output logic [STATE_W-1:0] cur_state [NUM_MOD]
);
  genvar i;
  generate
    for (i = 0; i < NUM_MOD; i++) begin : g_mod
      logic [STATE_W-1:0] target_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    target_q <= MS_OFF_RESET;
        else if (snap) target_q <= req_state[i];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cur_state[i] <= MS_OFF_RESET;
        else if (commit) cur_state[i] <= target_q;
      end

      AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(cur_state[i])); // R5
      AST_STATUS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        snap |=> target_q == $past(req_state[i])); // R6
    end
  endgenerate
endmodule

// File: rtl/psc_ctrl.sv
module psc_ctrl
  import psc_pkg::*;
#(
  parameter int NUM_MOD     = 64,
  parameter int XFER_CYCLES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               xfer_busy,
  output logic [NUM_MOD-1:0] mod_clk_en,
  output logic [NUM_MOD-1:0] mod_rst_n
);
  logic              hit_go, hit_busy, hit_ctrl, hit_stat;
  logic [5:0]        idx;
  logic [NUM_MOD-1:0] wr_sel;
  logic [DATA_W-1:0] ctrl_q [NUM_MOD];
  logic [STATE_W-1:0] req_state [NUM_MOD];
  logic [STATE_W-1:0] cur_state [NUM_MOD];
  logic              go_req, accept, commit, busy_q;
  logic [DATA_W-1:0] rd_mux, rdata_q;

  psc_addr_dec #(.NUM_MOD(NUM_MOD)) u_dec (
    .addr(reg_addr), .hit_go(hit_go), .hit_busy(hit_busy),
    .hit_ctrl(hit_ctrl), .hit_stat(hit_stat), .idx(idx)
  );

  always_comb begin
    go_req = reg_wr && hit_go && reg_wdata[0];
    for (int k = 0; k < NUM_MOD; k++)
      wr_sel[k] = reg_wr && hit_ctrl && (idx == 6'(k));
  end

  psc_ctrl_bank #(.NUM_MOD(NUM_MOD)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_sel(wr_sel), .wdata(reg_wdata), .ctrl_q(ctrl_q)
  );

  psc_xfer_seq #(.XFER_CYCLES(XFER_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .go_req(go_req),
    .busy_q(busy_q), .accept(accept), .commit(commit)
  );

  genvar i;
  generate
    for (i = 0; i < NUM_MOD; i++) begin : g_out
      always_comb begin
        req_state[i]  = ctrl_q[i][STATE_W-1:0];
        mod_rst_n[i]  = ctrl_q[i][LRST_BIT];
        mod_clk_en[i] = (cur_state[i] == MS_RUN);
      end

      AST_RST_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sel[i] |=> mod_rst_n[i] == $past(reg_wdata[LRST_BIT])); // R8
    end
  endgenerate

  psc_state_bank #(.NUM_MOD(NUM_MOD)) u_state (
    .clk(clk), .rst_n(rst_n), .snap(accept), .commit(commit),
    .req_state(req_state), .cur_state(cur_state)
  );

  always_comb begin
    rd_mux = '0;
    if (hit_busy)      rd_mux = {{(DATA_W-1){1'b0}}, busy_q};
    else if (hit_ctrl) rd_mux = ctrl_q[idx];
    else if (hit_stat) rd_mux = {{(DATA_W-STATE_W){1'b0}}, cur_state[idx]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (reg_rd) rdata_q <= rd_mux;
  end

  assign reg_rdata = rdata_q;
  assign xfer_busy = busy_q;

  AST_CLKEN_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(mod_clk_en)); // R3
  AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(go_req)); // R4
endmodule

// File: tb/psc_ctrl_test.sv
module psc_ctrl_test;
  localparam int NM = 64;
  localparam int XC = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic reg_wr, reg_rd;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic xfer_busy;
  logic [NM-1:0] mod_clk_en, mod_rst_n;

  int errors = 0;
  int checks = 0;
  logic [31:0] m_ctrl [NM];
  logic [4:0]  m_stat [NM];

  always #2 clk = ~clk;

  psc_ctrl #(.NUM_MOD(NM), .XFER_CYCLES(XC)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .xfer_busy(xfer_busy), .mod_clk_en(mod_clk_en), .mod_rst_n(mod_rst_n)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [NM-1:0] exp_clk_en();
    logic [NM-1:0] v;
    for (int k = 0; k < NM; k++) v[k] = (m_stat[k] == 5'd3);
    return v;
  endfunction

  function automatic logic [NM-1:0] exp_rst_n();
    logic [NM-1:0] v;
    for (int k = 0; k < NM; k++) v[k] = m_ctrl[k][8];
    return v;
  endfunction

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    @(posedge clk);
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wr_ctrl(input int n, input logic [31:0] d);
    wr(12'hA00 + 12'(4 * n), d);
    m_ctrl[n] = d;
    chk(mod_rst_n === exp_rst_n(), "R8 rst_n after ctrl write", 64'(mod_rst_n), 64'(exp_rst_n()));
    chk(mod_clk_en === exp_clk_en(), "R3 clk_en unchanged by ctrl write", 64'(mod_clk_en), 64'(exp_clk_en()));
  endtask

  task automatic wait_window(input int already);
    for (int k = already; k < XC; k++) begin
      chk(xfer_busy === 1'b1, "R4 busy held in window", 64'(xfer_busy), 64'd1);
      chk(mod_clk_en === exp_clk_en(), "R5 outputs stable while busy", 64'(mod_clk_en), 64'(exp_clk_en()));
      @(negedge clk);
    end
    chk(xfer_busy === 1'b0, "R4 busy clears after XFER_CYCLES", 64'(xfer_busy), 64'd0);
  endtask

  task automatic commit_all();
    wr(12'h120, 32'h1);
    wait_window(0);
    for (int k = 0; k < NM; k++) m_stat[k] = m_ctrl[k][4:0];
    chk(mod_clk_en === exp_clk_en(), "R7 clk_en after commit", 64'(mod_clk_en), 64'(exp_clk_en()));
  endtask

  task automatic check_all_regs();
    logic [31:0] d;
    for (int k = 0; k < NM; k++) begin
      rd(12'h800 + 12'(4 * k), d);
      chk(d === {27'd0, m_stat[k]}, "R6 status equals committed request", 64'(d), 64'(m_stat[k]));
      rd(12'hA00 + 12'(4 * k), d);
      chk(d === m_ctrl[k], "R2 ctrl readback", 64'(d), 64'(m_ctrl[k]));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int seed_dummy;
    seed_dummy = $urandom(32'd4242);
    for (int k = 0; k < NM; k++) begin m_ctrl[k] = '0; m_stat[k] = '0; end
    reg_wr = 0; reg_rd = 0; reg_addr = '0; reg_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(xfer_busy === 1'b0, "R1 busy after reset", 64'(xfer_busy), 64'd0);
    chk(mod_clk_en === '0, "R1 clk_en after reset", 64'(mod_clk_en), 64'd0);
    chk(mod_rst_n === '0, "R1 rst_n after reset", 64'(mod_rst_n), 64'd0);
    rd(12'h800 + 12'd4 * 12'd63, d);
    chk(d === 32'd0, "R1 status after reset", 64'(d), 64'd0);
    rd(12'hA00, d);
    chk(d === 32'd0, "R1 ctrl after reset", 64'(d), 64'd0);

    // R10 unmapped and command register reads
    rd(12'h120, d);
    chk(d === 32'd0, "R10 read of 0x120", 64'(d), 64'd0);
    wr(12'h404, 32'hFFFF_FFFF);
    rd(12'h404, d);
    chk(d === 32'd0, "R10 unmapped read", 64'(d), 64'd0);
    rd(12'hA02, d);
    chk(d === 32'd0, "R10 unaligned read", 64'(d), 64'd0);
    chk(mod_rst_n === '0, "R10 unmapped write no effect", 64'(mod_rst_n), 64'd0);

    // R4 command with bit 0 clear
    wr(12'h120, 32'hFFFF_FFFE);
    chk(xfer_busy === 1'b0, "R4 go with bit0 clear ignored", 64'(xfer_busy), 64'd0);

    // Directed: module 0 and last module to running, busy read via register
    wr_ctrl(0, 32'h0000_0103);
    wr_ctrl(NM - 1, 32'hABC0_0103);
    wr(12'h120, 32'h1);
    rd(12'h128, d);
    chk(d === 32'd1, "R4 busy bit at 0x128", 64'(d), 64'd1);
    wait_window(1);
    m_stat[0] = 5'd3; m_stat[NM-1] = 5'd3;
    chk(mod_clk_en === exp_clk_en(), "R7 running modules enabled", 64'(mod_clk_en), 64'(exp_clk_en()));
    rd(12'h800 + 12'd4 * 12'd63, d);
    chk(d === 32'd3, "R5 status of last module", 64'(d), 64'd3);

    // R9 and R6: command during busy, request changed mid-window
    wr_ctrl(5, 32'h0000_0103);
    wr(12'h120, 32'h1);
    wr_ctrl(5, 32'h0000_0102);
    wr(12'h120, 32'h1);
    wait_window(2);
    m_stat[5] = 5'd3;
    chk(mod_clk_en === exp_clk_en(), "R6 snapshot at accept", 64'(mod_clk_en), 64'(exp_clk_en()));
    @(negedge clk);
    chk(xfer_busy === 1'b0, "R9 second go ignored", 64'(xfer_busy), 64'd0);
    rd(12'h814, d);
    chk(d === 32'd3, "R6 status keeps snapshot", 64'(d), 64'd3);
    commit_all();
    rd(12'h814, d);
    chk(d === 32'd2, "R6 later request at next go", 64'(d), 64'd2);

    // Random rounds
    for (int r = 0; r < 12; r++) begin
      for (int j = 0; j < 6; j++) begin
        int n;
        logic [31:0] v;
        n = int'($urandom % NM);
        v = $urandom;
        if ($urandom % 5 == 0) v[4:0] = 5'($urandom);
        else                   v[4:0] = 5'($urandom % 4);
        wr_ctrl(n, v);
      end
      commit_all();
      if (r % 4 == 3) check_all_regs();
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule